// File: doc/BRIEF.md
# Low-Power Clock Gating Sequencer

This block sets the clock-gate enables of a small system-on-chip as it moves through full run, two light sleep modes (wait and doze) and a deep stop mode. In light sleep the processor, Flash and SRAM clocks are gated off while the peripheral clocks keep running. In stop every system clock is gated off. A field captured on stop entry chooses whether the PLL and the oscillator are also asked to power down.

Wakeup from stop runs as an ordered sequence. The block first waits for the oscillator to report ready, then waits for PLL lock, and then clocks the Flash alone for a fixed warm-up period before the rest of the system clocks are enabled. A control bit skips the lock wait. External clock mode skips both waits. A lock-wait timer raises an error flag if lock does not arrive, so a failed PLL does not leave the lock wait silent.

The block also turns loss of clock, or a drop of PLL lock, into a reset request while the PLL is in use, and that request returns the sequencer to run. There is no data stream: every pin is a plain level or single-cycle control signal, so no valid/ready handshake or back-pressure applies. Outputs come from registers and change on the clock edge after the inputs that cause them.

Top module: `lpc_clock_sequencer`

## Requirements
- R1: After reset the state code is RUN (0) and the cpu, flash, sram, periph and clkout enables are all high. A sleep request with mode 00 is ignored and the block stays in RUN.
- R2: A sleep request (`lp_enter` high for one cycle) moves the block on the next cycle. Mode 01 enters WAIT (state 1) and mode 10 enters DOZE (state 2). In both, cpu, flash and sram enables are low while periph and clkout stay high.
- R3: A wake event in WAIT or DOZE returns the block to RUN on the next cycle with all enables high, with no Flash warm-up phase.
- R4: Mode 11 enters STOP (state 3), where cpu, flash, sram and periph enables are all low. `stop_pd_sel` is captured on entry: bit 0 requests PLL power-down and bit 1 requests oscillator power-down. `pll_pwrdn` and `osc_pwrdn` follow the captured bits only while in STOP.
- R5: In STOP, `clkout_en` is high only if `clkout_stop_en` was high at entry and the PLL is not powered down.
- R6: A wake event in STOP, outside external clock mode, enters OSC_WAIT (4). The block stays there until `osc_ready`. If the bypass bit is clear it then enters LOCK_WAIT (5) and stays until `pll_locked`, then enters FLASH_WARMUP (6).
- R7: With `lock_bypass` set, OSC_WAIT goes straight to FLASH_WARMUP. With `ext_clk_mode` set, a wake event in STOP goes straight to FLASH_WARMUP.
- R8: FLASH_WARMUP lasts exactly WARMUP_CYCLES cycles (default 16) with only the flash enable high, and then the block enters RUN. clkout is low in states 4, 5 and 6.
- R9: After LOCK_LIMIT cycles in LOCK_WAIT, `lock_timeout_err` rises and stays high while the block remains in LOCK_WAIT. It clears when lock moves the block to FLASH_WARMUP.
- R10: While the PLL is active, a reset request is raised for one cycle per event in two cases: `pll_clk_lost` high with `rst_on_clk_loss_en` set, or a 1-to-0 drop of `pll_locked` with `rst_on_lock_loss_en` set. "Active" means not external clock mode, not powered down and not in states 4 or 5. The state becomes RUN on the same edge, which ends any sleep mode.
- R11: No reset request is raised when the matching enable is clear or when the PLL is powered down in STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_enter | input | 1 | One-cycle sleep request |
| lp_mode | input | 2 | Requested mode: 01 wait, 10 doze, 11 stop |
| wake_evt | input | 1 | Wakeup event |
| pll_locked | input | 1 | PLL lock indicator |
| pll_clk_lost | input | 1 | Loss-of-clock indicator |
| osc_ready | input | 1 | Oscillator startup complete |
| stop_pd_sel | input | 2 | Stop power-down choice: bit0 PLL, bit1 oscillator |
| clkout_stop_en | input | 1 | Keep clock-out running during stop |
| lock_bypass | input | 1 | Skip the lock wait on stop wakeup |
| ext_clk_mode | input | 1 | External clock mode, skips both waits |
| rst_on_clk_loss_en | input | 1 | Reset on loss of clock |
| rst_on_lock_loss_en | input | 1 | Reset on loss of lock |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| flash_clk_en | output | 1 | Flash clock gate enable |
| sram_clk_en | output | 1 | SRAM clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| clkout_en | output | 1 | External clock-out enable |
| pll_pwrdn | output | 1 | PLL power-down request |
| osc_pwrdn | output | 1 | Oscillator power-down request |
| rst_req | output | 1 | Reset request |
| lock_timeout_err | output | 1 | Lock wait exceeded its limit |
| seq_state | output | 3 | Current sequencer state code |

## Verification
The assertions check these rules on every cycle:
- the gate pattern in light sleep and in stop;
- that clkout is off while the PLL is powered down;
- that the oscillator-ready and lock conditions held whenever a wait state was left;
- the exact warm-up length on every return to run;
- that the timeout flag only appears in the lock wait;
- that a reset request always coincides with RUN.

Only the bench scenarios show the rest:
- the captured power-down field and clock-out choice;
- the cycle-exact paths through the bypass and external clock options;
- the timeout arriving after the configured limit;
- that a reset request is suppressed when its enable is clear or the PLL is powered down.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [2:0] {
    SEQ_RUN    = 3'd0,
    SEQ_WAIT   = 3'd1,
    SEQ_DOZE   = 3'd2,
    SEQ_STOP   = 3'd3,
    SEQ_OSC    = 3'd4,
    SEQ_LOCK   = 3'd5,
    SEQ_WARMUP = 3'd6
  } seq_state_e;

  typedef enum logic [1:0] {
    LPM_NONE = 2'd0,
    LPM_WAIT = 2'd1,
    LPM_DOZE = 2'd2,
    LPM_STOP = 2'd3
  } lp_mode_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic sram;
    logic periph;
    logic clkout;
    logic pll_pd;
    logic osc_pd;
  } gate_vec_t;

endpackage

// File: rtl/lpc_phase_counter.sv
// Counts consecutive cycles that a phase is active; clears when inactive.
module lpc_phase_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic at_last,
  output logic at_full
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] FULL = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active) begin
      cnt_q <= '0;
    end else if (cnt_q != FULL) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign at_last = (cnt_q == LAST);
  assign at_full = (cnt_q == FULL);
endmodule

// File: rtl/lpc_loss_monitor.sv
// Turns clock loss or lock drop into a registered reset request.
module lpc_loss_monitor
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state,
  input  logic       pll_pd_now,
  input  logic       ext_clk_mode,
  input  logic       pll_locked,
  input  logic       pll_clk_lost,
  input  logic       clk_loss_en,
  input  logic       lock_loss_en,
  output logic       rst_event,
  output logic       rst_req
);
  logic lock_prev_q;
  logic pll_active;
  logic lock_drop;

  assign pll_active = !ext_clk_mode && !pll_pd_now &&
                      (state != SEQ_OSC) && (state != SEQ_LOCK);
  assign lock_drop  = lock_prev_q && !pll_locked;
  assign rst_event  = pll_active &&
                      ((clk_loss_en && pll_clk_lost) || (lock_loss_en && lock_drop));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_prev_q <= 1'b0;
      rst_req     <= 1'b0;
    end else begin
      lock_prev_q <= pll_locked;
      rst_req     <= rst_event;
    end
  end
endmodule

// File: rtl/lpc_seq_fsm.sv
// Mode and wakeup state machine with stop configuration capture.
module lpc_seq_fsm
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lp_enter,
  input  lp_mode_e   lp_mode,
  input  logic       wake_evt,
  input  logic       osc_ready,
  input  logic       pll_locked,
  input  logic       lock_bypass,
  input  logic       ext_clk_mode,
  input  logic [1:0] stop_pd_sel,
  input  logic       clkout_stop_en,
  input  logic       warm_done,
  input  logic       rst_event,
  output seq_state_e state,
  output logic [1:0] stop_pd_q,
  output logic       stop_co_q
);
  seq_state_e nxt;
  logic       take_stop;

  assign take_stop = (state == SEQ_RUN) && lp_enter && (lp_mode == LPM_STOP) && !rst_event;

  always_comb begin
    nxt = state;
    unique case (state)
      SEQ_RUN: begin
        if (lp_enter) begin
          unique case (lp_mode)
            LPM_WAIT: nxt = SEQ_WAIT;
            LPM_DOZE: nxt = SEQ_DOZE;
            LPM_STOP: nxt = SEQ_STOP;
            default:  nxt = SEQ_RUN;
          endcase
        end
      end
      SEQ_WAIT, SEQ_DOZE: if (wake_evt) nxt = SEQ_RUN;
      SEQ_STOP: if (wake_evt) nxt = ext_clk_mode ? SEQ_WARMUP : SEQ_OSC;
      SEQ_OSC:  if (osc_ready) nxt = lock_bypass ? SEQ_WARMUP : SEQ_LOCK;
      SEQ_LOCK: if (pll_locked) nxt = SEQ_WARMUP;
      SEQ_WARMUP: if (warm_done) nxt = SEQ_RUN;
      default: nxt = SEQ_RUN;
    endcase
    if (rst_event) nxt = SEQ_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_RUN;
      stop_pd_q <= 2'b00;
      stop_co_q <= 1'b0;
    end else begin
      state <= nxt;
      if (take_stop) begin
        stop_pd_q <= stop_pd_sel;
        stop_co_q <= clkout_stop_en;
      end
    end
  end
endmodule

// File: rtl/lpc_gate_decode.sv
// Maps the sequencer state to clock gate enables and power-down requests.
module lpc_gate_decode
  import lpc_pkg::*;
(
  input  seq_state_e state,
  input  logic [1:0] stop_pd_q,
  input  logic       stop_co_q,
  output gate_vec_t  gates
);
  always_comb begin
    gates = '0;
    unique case (state)
      SEQ_RUN: begin
        gates.cpu = 1'b1; gates.flash = 1'b1; gates.sram = 1'b1;
        gates.periph = 1'b1; gates.clkout = 1'b1;
      end
      SEQ_WAIT, SEQ_DOZE: begin
        gates.periph = 1'b1; gates.clkout = 1'b1;
      end
      SEQ_STOP: begin
        gates.pll_pd = stop_pd_q[0];
        gates.osc_pd = stop_pd_q[1];
        gates.clkout = stop_co_q && !stop_pd_q[0];
      end
      SEQ_WARMUP: gates.flash = 1'b1;
      default: gates = '0;
    endcase
  end
endmodule

// File: rtl/lpc_clock_sequencer.sv
module lpc_clock_sequencer
  import lpc_pkg::*;
#(
  parameter int WARMUP_CYCLES = 16,
  parameter int LOCK_LIMIT    = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lp_enter,
  input  logic [1:0] lp_mode,
  input  logic       wake_evt,
  input  logic       pll_locked,
  input  logic       pll_clk_lost,
  input  logic       osc_ready,
  input  logic [1:0] stop_pd_sel,
  input  logic       clkout_stop_en,
  input  logic       lock_bypass,
  input  logic       ext_clk_mode,
  input  logic       rst_on_clk_loss_en,
  input  logic       rst_on_lock_loss_en,
  output logic       cpu_clk_en,
  output logic       flash_clk_en,
  output logic       sram_clk_en,
  output logic       periph_clk_en,
  output logic       clkout_en,
  output logic       pll_pwrdn,
  output logic       osc_pwrdn,
  output logic       rst_req,
  output logic       lock_timeout_err,
  output logic [2:0] seq_state
);
  seq_state_e st;
  logic [1:0] stop_pd_q;
  logic       stop_co_q;
  logic       warm_last, warm_full_unused;
  logic       lock_last_unused, lock_full;
  logic       rst_event;
  gate_vec_t  gates;

  lpc_seq_fsm u_fsm (
    .clk, .rst_n, .lp_enter,
    .lp_mode       (lp_mode_e'(lp_mode)),
    .wake_evt, .osc_ready, .pll_locked, .lock_bypass, .ext_clk_mode,
    .stop_pd_sel, .clkout_stop_en,
    .warm_done     (warm_last),
    .rst_event,
    .state         (st),
    .stop_pd_q, .stop_co_q
  );

  lpc_phase_counter #(.LIMIT(WARMUP_CYCLES)) u_warm (
    .clk, .rst_n,
    .active  (st == SEQ_WARMUP),
    .at_last (warm_last),
    .at_full (warm_full_unused)
  );

  lpc_phase_counter #(.LIMIT(LOCK_LIMIT)) u_lock_tmr (
    .clk, .rst_n,
    .active  (st == SEQ_LOCK),
    .at_last (lock_last_unused),
    .at_full (lock_full)
  );

  lpc_gate_decode u_dec (
    .state (st), .stop_pd_q, .stop_co_q, .gates
  );

  lpc_loss_monitor u_loss (
    .clk, .rst_n,
    .state        (st),
    .pll_pd_now   (gates.pll_pd),
    .ext_clk_mode,
    .pll_locked, .pll_clk_lost,
    .clk_loss_en  (rst_on_clk_loss_en),
    .lock_loss_en (rst_on_lock_loss_en),
    .rst_event,
    .rst_req
  );

  assign cpu_clk_en       = gates.cpu;
  assign flash_clk_en     = gates.flash;
  assign sram_clk_en      = gates.sram;
  assign periph_clk_en    = gates.periph;
  assign clkout_en        = gates.clkout;
  assign pll_pwrdn        = gates.pll_pd;
  assign osc_pwrdn        = gates.osc_pd;
  assign lock_timeout_err = lock_full && (st == SEQ_LOCK);
  assign seq_state        = st;
endmodule

// File: rtl/lpc_clock_sequencer_chk.sv
module lpc_clock_sequencer_chk
  import lpc_pkg::*;
#(
  parameter int WARMUP_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_ready,
  input logic       pll_locked,
  input logic       cpu_clk_en,
  input logic       flash_clk_en,
  input logic       sram_clk_en,
  input logic       periph_clk_en,
  input logic       clkout_en,
  input logic       pll_pwrdn,
  input logic       rst_req,
  input logic       lock_timeout_err,
  input logic [2:0] seq_state
);
  localparam int WW = $clog2(WARMUP_CYCLES + 1) + 1;
  logic [WW-1:0] warm_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_cnt <= '0;
    else if (seq_state == SEQ_WARMUP) warm_cnt <= warm_cnt + 1'b1;
    else warm_cnt <= '0;
  end

  p_sleep_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_WAIT || seq_state == SEQ_DOZE) |->
      (!cpu_clk_en && !flash_clk_en && !sram_clk_en && periph_clk_en));

  p_stop_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_STOP) |->
      (!cpu_clk_en && !flash_clk_en && !sram_clk_en && !periph_clk_en));

  p_clkout_pll_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pll_pwrdn |-> !clkout_en);

  p_osc_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_LOCK && $past(seq_state) == SEQ_OSC) |-> $past(osc_ready));

  p_lock_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_WARMUP && $past(seq_state) == SEQ_LOCK) |-> $past(pll_locked));

  p_warm_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_RUN && $past(seq_state) == SEQ_WARMUP && !rst_req) |->
      (warm_cnt == WW'(WARMUP_CYCLES)));

  p_err_in_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_timeout_err |-> (seq_state == SEQ_LOCK));

  p_rst_to_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (seq_state == SEQ_RUN));
endmodule

bind lpc_clock_sequencer lpc_clock_sequencer_chk #(.WARMUP_CYCLES(WARMUP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_ready(osc_ready), .pll_locked(pll_locked),
  .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en), .sram_clk_en(sram_clk_en),
  .periph_clk_en(periph_clk_en), .clkout_en(clkout_en), .pll_pwrdn(pll_pwrdn),
  .rst_req(rst_req), .lock_timeout_err(lock_timeout_err), .seq_state(seq_state)
);

// File: tb/sim_lpc_clock_sequencer.sv
`timescale 1ns/1ps
module sim_lpc_clock_sequencer;
  localparam int LIM = 20;
  localparam logic [2:0] S_RUN = 3'd0, S_WAIT = 3'd1, S_DOZE = 3'd2, S_STOP = 3'd3,
                         S_OSC = 3'd4, S_LOCK = 3'd5, S_WARM = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_enter = 0, wake_evt = 0, pll_locked = 1, pll_clk_lost = 0, osc_ready = 1;
  logic [1:0] lp_mode = 0, stop_pd_sel = 0;
  logic clkout_stop_en = 0, lock_bypass = 0, ext_clk_mode = 0;
  logic rst_on_clk_loss_en = 0, rst_on_lock_loss_en = 0;
  logic cpu_clk_en, flash_clk_en, sram_clk_en, periph_clk_en, clkout_en;
  logic pll_pwrdn, osc_pwrdn, rst_req, lock_timeout_err;
  logic [2:0] seq_state;

  always #10 clk = ~clk;

  lpc_clock_sequencer #(.WARMUP_CYCLES(16), .LOCK_LIMIT(LIM)) u0 (.*);

  typedef struct { int when; logic [11:0] v; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [11:0] vx(input logic [2:0] s, input logic co, pp, op, rq, er);
    logic [3:0] g;
    case (s)
      S_RUN:          g = 4'b1111;
      S_WAIT, S_DOZE: g = 4'b0001;
      S_WARM:         g = 4'b0100;
      default:        g = 4'b0000;
    endcase
    return {g, co, pp, op, rq, er, s};
  endfunction

  task automatic exp_at(input int k, input logic [11:0] v, input string tag);
    exp_t e;
    e.when = cyc + k; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares due expectations shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].when == cyc) begin
          logic [11:0] act;
          act = {cpu_clk_en, flash_clk_en, sram_clk_en, periph_clk_en, clkout_en,
                 pll_pwrdn, osc_pwrdn, rst_req, lock_timeout_err, seq_state};
          checks++;
          if (act !== q[i].v) begin
            errors++;
            $display("FAIL %s cycle %0d actual %b expected %b", q[i].tag, cyc, act, q[i].v);
          end
          q.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    exp_at(1, vx(S_RUN,1,0,0,0,0), "R1 reset state");
    tick(2);
    // R1: mode 00 ignored
    lp_enter = 1; lp_mode = 2'b00;
    exp_at(1, vx(S_RUN,1,0,0,0,0), "R1 mode00 ignored");
    tick(1); lp_enter = 0;
    exp_at(1, vx(S_RUN,1,0,0,0,0), "R1 still run");
    tick(1);
    // R2/R3 wait
    lp_enter = 1; lp_mode = 2'b01;
    exp_at(1, vx(S_WAIT,1,0,0,0,0), "R2 wait gates");
    tick(1); lp_enter = 0;
    exp_at(2, vx(S_WAIT,1,0,0,0,0), "R2 wait held");
    tick(2); wake_evt = 1;
    exp_at(1, vx(S_RUN,1,0,0,0,0), "R3 wake from wait");
    tick(1); wake_evt = 0;
    // doze
    lp_enter = 1; lp_mode = 2'b10;
    exp_at(1, vx(S_DOZE,1,0,0,0,0), "R2 doze gates");
    tick(1); lp_enter = 0; wake_evt = 1;
    exp_at(1, vx(S_RUN,1,0,0,0,0), "R3 wake from doze");
    tick(1); wake_evt = 0;
    // R4/R5/R6/R8: stop, nothing powered down, clkout kept
    stop_pd_sel = 2'b00; clkout_stop_en = 1; lp_enter = 1; lp_mode = 2'b11;
    exp_at(1, vx(S_STOP,1,0,0,0,0), "R4 R5 stop pd00 clkout on");
    tick(1); lp_enter = 0; wake_evt = 1;
    exp_at(1, vx(S_OSC,0,0,0,0,0), "R6 osc wait");
    exp_at(2, vx(S_LOCK,0,0,0,0,0), "R6 lock wait");
    exp_at(3, vx(S_WARM,0,0,0,0,0), "R8 warmup start");
    exp_at(18, vx(S_WARM,0,0,0,0,0), "R8 warmup last");
    exp_at(19, vx(S_RUN,1,0,0,0,0), "R8 run after 16");
    tick(1); wake_evt = 0;
    tick(20);
    // both powered down, waits hold
    stop_pd_sel = 2'b11; lp_enter = 1;
    exp_at(1, vx(S_STOP,0,1,1,0,0), "R4 R5 stop pd11");
    tick(1); lp_enter = 0; pll_locked = 0; osc_ready = 0;
    exp_at(2, vx(S_STOP,0,1,1,0,0), "R4 stop held");
    tick(2); wake_evt = 1;
    exp_at(1, vx(S_OSC,0,0,0,0,0), "R6 enter osc wait");
    tick(1); wake_evt = 0;
    exp_at(3, vx(S_OSC,0,0,0,0,0), "R6 osc wait holds");
    tick(3); osc_ready = 1;
    exp_at(1, vx(S_LOCK,0,0,0,0,0), "R6 to lock wait");
    exp_at(4, vx(S_LOCK,0,0,0,0,0), "R6 lock wait holds");
    tick(4); pll_locked = 1;
    exp_at(1, vx(S_WARM,0,0,0,0,0), "R6 lock to warmup");
    tick(20);
    // R7 bypass
    stop_pd_sel = 2'b01; lock_bypass = 1; lp_enter = 1;
    exp_at(1, vx(S_STOP,0,1,0,0,0), "R5 clkout off pll down");
    tick(1); lp_enter = 0; pll_locked = 0; wake_evt = 1;
    exp_at(1, vx(S_OSC,0,0,0,0,0), "R7 bypass osc");
    exp_at(2, vx(S_WARM,0,0,0,0,0), "R7 bypass skips lock");
    exp_at(17, vx(S_WARM,0,0,0,0,0), "R8 bypass warm last");
    exp_at(18, vx(S_RUN,1,0,0,0,0), "R8 bypass run");
    tick(1); wake_evt = 0;
    tick(20); lock_bypass = 0; pll_locked = 1;
    // R7 external clock
    ext_clk_mode = 1; stop_pd_sel = 2'b00; clkout_stop_en = 0; lp_enter = 1;
    exp_at(1, vx(S_STOP,0,0,0,0,0), "R5 clkout not requested");
    tick(1); lp_enter = 0; wake_evt = 1;
    exp_at(1, vx(S_WARM,0,0,0,0,0), "R7 ext skips waits");
    exp_at(17, vx(S_RUN,1,0,0,0,0), "R8 ext run");
    tick(1); wake_evt = 0;
    tick(18); ext_clk_mode = 0;
    // R9 lock timeout
    pll_locked = 0; lp_enter = 1;
    exp_at(1, vx(S_STOP,0,0,0,0,0), "R9 stop");
    tick(1); lp_enter = 0; wake_evt = 1;
    exp_at(2, vx(S_LOCK,0,0,0,0,0), "R9 lock wait");
    exp_at(LIM + 1, vx(S_LOCK,0,0,0,0,0), "R9 no err before limit");
    exp_at(LIM + 2, vx(S_LOCK,0,0,0,0,1), "R9 err at limit");
    exp_at(LIM + 10, vx(S_LOCK,0,0,0,0,1), "R9 err held");
    tick(1); wake_evt = 0;
    tick(LIM + 9); pll_locked = 1;
    exp_at(1, vx(S_WARM,0,0,0,0,0), "R9 err clears");
    tick(20);
    // R10 lock loss in wait
    rst_on_lock_loss_en = 1; lp_enter = 1; lp_mode = 2'b01;
    exp_at(1, vx(S_WAIT,1,0,0,0,0), "R10 wait");
    tick(1); lp_enter = 0; pll_locked = 0;
    exp_at(1, vx(S_RUN,1,0,0,1,0), "R10 lock loss reset");
    exp_at(2, vx(S_RUN,1,0,0,0,0), "R10 one pulse");
    tick(2); pll_locked = 1; rst_on_lock_loss_en = 0;
    tick(1);
    // R10 clock loss level
    rst_on_clk_loss_en = 1; pll_clk_lost = 1;
    exp_at(1, vx(S_RUN,1,0,0,1,0), "R10 clock loss reset");
    exp_at(3, vx(S_RUN,1,0,0,1,0), "R10 clock loss held");
    tick(3); pll_clk_lost = 0;
    exp_at(1, vx(S_RUN,1,0,0,0,0), "R10 released");
    tick(1);
    // R11 enable clear
    rst_on_clk_loss_en = 0; pll_clk_lost = 1;
    exp_at(1, vx(S_RUN,1,0,0,0,0), "R11 enable clear");
    tick(1); pll_clk_lost = 0;
    // R11 pll powered down in stop
    rst_on_clk_loss_en = 1; stop_pd_sel = 2'b01; lp_enter = 1; lp_mode = 2'b11;
    exp_at(1, vx(S_STOP,0,1,0,0,0), "R11 stop pll down");
    tick(1); lp_enter = 0; pll_clk_lost = 1;
    exp_at(1, vx(S_STOP,0,1,0,0,0), "R11 no reset pll down");
    exp_at(3, vx(S_STOP,0,1,0,0,0), "R11 still stop");
    tick(3); pll_clk_lost = 0; wake_evt = 1;
    tick(1); wake_evt = 0;
    tick(25);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule